// File: doc/BRIEF.md
# Tree-Structured Carry-Lookahead Adder

This block adds two unsigned operands of a parameterised, power-of-two width together with a carry-in. It returns the sum and a carry-out. No carry travels bit by bit. Instead, each bit position reports two flags: whether it creates a carry by itself (generate) and whether it passes an incoming carry through (propagate). A balanced binary tree of merge cells then combines these flags.

On the way up the tree, each cell merges the flags of a lower and an upper block into flags for the pair. On the way down, each cell takes the carry entering its block, passes it unchanged to the lower half, and works out the carry for the upper half from the lower half's flags. Each sum bit is then one XOR of that bit's propagate flag with its carry. The logic depth therefore grows with the logarithm of the width rather than with the width.

The block is purely combinational and has no clock. It is meant to sit inside a datapath stage where the critical path must not scale linearly with operand width.

Top module: `cla_tree_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + carry_i`, treating both operands as unsigned numbers.
- R2: `carry_o` equals bit WIDTH of `a_i + b_i + carry_i`, so that {carry_o, sum_o} is the full WIDTH+1-bit result.
- R3: When every bit of `a_i ^ b_i` is 1, the carry-in passes across the full width: `carry_o` equals `carry_i`, and `sum_o` is all ones for carry-in 0 and all zeros for carry-in 1.
- R4: All-ones plus one (a_i all ones, b_i = 1, carry_i = 0) gives `sum_o` = 0 and `carry_o` = 1.
- R5: A carry created at a single bit k (a_i = b_i = 1<<k, carry_i = 0) gives `sum_o` = 1<<(k+1) for k < WIDTH-1. For k = WIDTH-1 it gives `sum_o` = 0 and `carry_o` = 1.
- R6: The outputs follow any change of the inputs within the same time step, without waiting for a clock edge. A zero input with carry_i = 1 gives `sum_o` = 1 and `carry_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum, low WIDTH bits |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach is a carry that must cross every level of the tree: the propagate flags must be true at every node while the generate flags stay false. Random operands almost never produce this. The stimulus therefore builds it on purpose. It sets the operands to complementary values so that every bit propagates, then toggles the carry-in. It also walks a single generated carry through each bit position, so that every upper-half carry path in every cell is exercised.

// File: rtl/cla_pkg.sv
package cla_pkg;
    // Flags of a block: creates a carry / passes a carry through
    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;
endpackage

// File: rtl/cla_bit_slice.sv
module cla_bit_slice
    import cla_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output gp_t  gp_o,
    output logic s_o
);
    gp_t gp_d;

    always_comb begin
        gp_d.gen  = a_i & b_i;
        gp_d.prop = a_i ^ b_i;
    end

    assign gp_o = gp_d;
    assign s_o  = gp_d.prop ^ c_i;
endmodule

// File: rtl/cla_tree_cell.sv
module cla_tree_cell
    import cla_pkg::*;
(
    input  gp_t  lo_i,
    input  gp_t  hi_i,
    input  logic c_blk_i,
    output gp_t  gp_o,
    output logic c_lo_o,
    output logic c_hi_o
);
    gp_t gp_d;

    always_comb begin
        gp_d.gen  = hi_i.gen | (lo_i.gen & hi_i.prop);
        gp_d.prop = lo_i.prop & hi_i.prop;
    end

    assign gp_o   = gp_d;
    assign c_lo_o = c_blk_i;
    assign c_hi_o = lo_i.gen | (lo_i.prop & c_blk_i);

    // A block can never both create and pass a carry (supports R2)
    always_comb begin
        p_block_flags_excl_r2: assert ($onehot0({gp_d.gen, gp_d.prop}))
            else $error("block generate and propagate both high");
        // Whole block propagating: the upper half sees the block carry (R3)
        p_prop_passes_carry_r3: assert (!gp_d.prop || (c_hi_o == c_blk_i))
            else $error("propagating block altered carry");
    end
endmodule

// File: rtl/cla_tree_adder.sv
module cla_tree_adder
    import cla_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o
);
    localparam int NODES = 2 * WIDTH;

    // Heap layout: node 1 is the root, node n has children 2n (low) and
    // 2n+1 (high), leaves WIDTH..2*WIDTH-1 are bits 0..WIDTH-1.
    gp_t  node_gp [1:NODES-1];
    logic [NODES-1:1] node_c;

    initial begin
        if ((WIDTH < 2) || ((WIDTH & (WIDTH - 1)) != 0))
            $error("WIDTH must be a power of two, at least 2");
    end

    assign node_c[1] = carry_i;

    for (genvar k = 0; k < WIDTH; k++) begin : g_slice
        cla_bit_slice u_slice (
            .a_i  (a_i[k]),
            .b_i  (b_i[k]),
            .c_i  (node_c[WIDTH + k]),
            .gp_o (node_gp[WIDTH + k]),
            .s_o  (sum_o[k])
        );
    end

    for (genvar n = 1; n < WIDTH; n++) begin : g_cell
        cla_tree_cell u_cell (
            .lo_i    (node_gp[2 * n]),
            .hi_i    (node_gp[2 * n + 1]),
            .c_blk_i (node_c[n]),
            .gp_o    (node_gp[n]),
            .c_lo_o  (node_c[2 * n]),
            .c_hi_o  (node_c[2 * n + 1])
        );
    end

    assign carry_o = node_gp[1].gen | (node_gp[1].prop & carry_i);

    logic [WIDTH:0] ref_total;
    always_comb begin
        ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};
        p_sum_matches_r1: assert (sum_o == ref_total[WIDTH-1:0])
            else $error("sum differs from arithmetic result");
        p_carry_matches_r2: assert (carry_o == ref_total[WIDTH])
            else $error("carry-out differs from arithmetic result");
        p_full_propagate_r3: assert (!(&(a_i ^ b_i)) || (carry_o == carry_i))
            else $error("full propagate did not pass carry-in");
    end
endmodule

// File: tb/cla_tree_adder_tb.sv
module cla_tree_adder_tb_top;
    localparam int WIDTH = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [WIDTH-1:0] a, b, sum;
    logic             cin, cout;
    int n_checks = 0;
    int n_fail   = 0;

    cla_tree_adder #(.WIDTH(WIDTH)) dut_i (
        .a_i(a), .b_i(b), .carry_i(cin), .sum_o(sum), .carry_o(cout)
    );

    task automatic compare(input string req, input logic [WIDTH-1:0] es,
                           input logic ec);
        n_checks++;
        if (sum !== es || cout !== ec) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h cin=%0d got sum=%h cout=%0d exp sum=%h cout=%0d",
                     req, a, b, cin, sum, cout, es, ec);
        end
    endtask

    task automatic apply_ref(input string req, input logic [WIDTH-1:0] x,
                             input logic [WIDTH-1:0] y, input logic ci);
        logic [WIDTH:0] t;
        @(negedge clk);
        a = x; b = y; cin = ci;
        #1;
        t = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
        compare(req, t[WIDTH-1:0], t[WIDTH]);
    endtask

    task automatic test_reset_state;
        @(negedge clk);
        a = '0; b = '0; cin = 1'b0;
        #1 compare("R1 zero", '0, 1'b0);
    endtask

    task automatic test_random;
        for (int i = 0; i < 400; i++)
            apply_ref((i % 2) ? "R2 random" : "R1 random",
                      $urandom, $urandom, 1'($urandom));
    endtask

    task automatic test_full_propagate;
        for (int i = 0; i < 8; i++) begin
            logic [WIDTH-1:0] x;
            x = $urandom;
            @(negedge clk);
            a = x; b = ~x; cin = 1'b0;
            #1 compare("R3 prop cin0", '1, 1'b0);
            cin = 1'b1;
            #1 compare("R3 prop cin1", '0, 1'b1);
        end
    endtask

    task automatic test_all_ones_plus_one;
        @(negedge clk);
        a = '1; b = WIDTH'(1); cin = 1'b0;
        #1 compare("R4 ones plus one", '0, 1'b1);
        apply_ref("R4 ones plus ones cin", '1, '1, 1'b1);
    endtask

    task automatic test_single_generate;
        for (int k = 0; k < WIDTH; k++) begin
            @(negedge clk);
            a = WIDTH'(1) << k; b = WIDTH'(1) << k; cin = 1'b0;
            #1;
            if (k == WIDTH - 1) compare("R5 top generate", '0, 1'b1);
            else compare("R5 generate", WIDTH'(1) << (k + 1), 1'b0);
        end
    endtask

    task automatic test_comb_response;
        @(negedge clk);
        a = '0; b = '0; cin = 1'b1;
        #1 compare("R6 cin only", WIDTH'(1), 1'b0);
        a = WIDTH'(5); b = WIDTH'(9); cin = 1'b0;
        #1 compare("R6 same step", WIDTH'(14), 1'b0);
    endtask

    initial begin
        fork
            begin
                test_reset_state();
                test_random();
                test_full_propagate();
                test_all_ones_plus_one();
                test_single_generate();
                test_comb_response();
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: expired, exp completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule